// File: doc/BRIEF.md
# UART Channel FIFO Pair with DMA Handshake

This block holds the transmit and receive byte queues of one serial channel, each 32 entries deep, and the FIFO control register that governs them. Bytes enter and leave through single-cycle push and pop strobes on both queues. An occupancy count is kept for each queue. From the counts and the register settings the block derives two active-low DMA request lines, a receive-threshold interrupt and a transmit-threshold interrupt.

The control register has five fields. Bit 0 enables the deep queues; when it is clear each queue acts as a one-byte holding register. Bit 3 selects the DMA signalling style. Bit 2 is a self-clearing transmit flush strobe. Bits 5:4 select the transmit threshold and bits 7:6 the receive threshold. A receive time-out pulse from an external timer feeds the block-transfer request logic. The serial shifters, the baud generator and the timer itself sit outside.

Top module: `uart_fifo_dma_ctrl`

## Requirements
- R1: After reset the control register reads 0x00. A write stores bits 7:6, 5:4, 3 and 0, and bits 2 and 1 always read back as 0.
- R2: With bit 0 clear, each queue accepts at most one byte. With bit 0 set, each queue accepts up to 32 bytes.
- R3: A push to a full queue is dropped and leaves the count unchanged. It sets that queue's overflow flag, which stays set until reset (or, for transmit, until a flush).
- R4: Pops return bytes in the order they were pushed, on the cycle after the pop strobe. A pop from an empty queue leaves the count at 0 and keeps the previous read data.
- R5: Writing the register with bit 2 set empties the transmit queue and clears its overflow flag in that cycle. The transmit read data is left as it was.
- R6: While bit 0 is set, the receive interrupt is high whenever the receive count is at or above the receive threshold. Bits 7:6 select the threshold: 00=8, 01=16, 10=24, 11=28. The interrupt is low while bit 0 is clear.
- R7: While bit 0 is set, the transmit interrupt is high whenever the transmit count is below the transmit threshold. Bits 5:4 select the threshold: 00=16, 01=8, 10=24, 11=28. The interrupt is low while bit 0 is clear.
- R8: Block-transfer signalling (mode 1) is in force only when both bit 0 and bit 3 are 1. In every other case single-transfer signalling (mode 0) applies.
- R9: In mode 0, txrdy_n is 0 exactly when the transmit queue is empty.
- R10: In mode 0, rxrdy_n is 0 exactly when the receive queue holds at least one byte.
- R11: In mode 1, txrdy_n is 1 when the transmit queue is full and 0 when the transmit count is at or below the transmit threshold. Between those two points it keeps its last value.
- R12: In mode 1, rxrdy_n falls when the receive count reaches the receive threshold, or when rx_timeout is high while the queue is not empty. It then stays 0 until the receive queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fcr_we | input | 1 | Control register write strobe |
| fcr_wdata | input | 8 | Control register write value |
| fcr_rdata | output | 8 | Control register read value |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Transmit byte to push |
| tx_pop | input | 1 | Pop a byte from the transmit queue |
| tx_rdata | output | 8 | Last byte popped from the transmit queue |
| tx_count | output | 6 | Transmit queue occupancy |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_wdata | input | 8 | Receive byte to push |
| rx_pop | input | 1 | Pop a byte from the receive queue |
| rx_rdata | output | 8 | Last byte popped from the receive queue |
| rx_count | output | 6 | Receive queue occupancy |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| rx_timeout | input | 1 | Receive time-out pulse from the external timer |
| txrdy_n | output | 1 | Active-low transmit DMA request |
| rxrdy_n | output | 1 | Active-low receive DMA request |
| tx_trig_irq | output | 1 | Transmit threshold interrupt |
| rx_trig_irq | output | 1 | Receive threshold interrupt |

## Verification
The hardest behaviour to reach is the hold band of the mode 1 transmit request. There the output depends on the direction the count came from, not on the count itself. The stimulus fills the transmit queue past its threshold to completely full, then drains it one byte at a time back through the band. It samples the request both on the way up and on the way down, and watches the transmit interrupt cross at the same threshold. The receive time-out path is reached with a partly filled queue below the threshold. It is then pulsed again with the queue empty to show that the request stays off.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    localparam int unsigned UFC_DW    = 8;
    localparam int unsigned UFC_DEPTH = 32;

    // control register image, MSB first
    typedef struct packed {
        logic [1:0] rx_sel;
        logic [1:0] tx_sel;
        logic       dma_sel;
        logic       tx_flush;
        logic       spare;
        logic       en;
    } ctl_reg_t;

    typedef enum logic {
        DMA_SINGLE = 1'b0,
        DMA_BLOCK  = 1'b1
    } dma_mode_e;

    function automatic int unsigned tx_threshold(input logic [1:0] sel,
                                                 input int unsigned depth);
        case (sel)
            2'b00:   return depth / 2;
            2'b01:   return depth / 4;
            2'b10:   return (depth * 3) / 4;
            default: return (depth * 7) / 8;
        endcase
    endfunction

    function automatic int unsigned rx_threshold(input logic [1:0] sel,
                                                 input int unsigned depth);
        case (sel)
            2'b00:   return depth / 4;
            2'b01:   return depth / 2;
            2'b10:   return (depth * 3) / 4;
            default: return (depth * 7) / 8;
        endcase
    endfunction

endpackage

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
    import ufc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output ctl_reg_t   ctl_q,
    output logic       tx_flush,
    output dma_mode_e  mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q.rx_sel   <= wdata[7:6];
            ctl_q.tx_sel   <= wdata[5:4];
            ctl_q.dma_sel  <= wdata[3];
            ctl_q.tx_flush <= 1'b0;
            ctl_q.spare    <= 1'b0;
            ctl_q.en       <= wdata[0];
        end
    end

    assign tx_flush = we && wdata[2];
    assign mode     = (ctl_q.en && ctl_q.dma_sel) ? DMA_BLOCK : DMA_SINGLE;

endmodule

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          ovf
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && !flush && (count_q < cap);
    assign do_pop  = pop  && !flush && (count_q != '0);

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
            ovf     <= 1'b0;
            rdata   <= '0;
        end else if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
            ovf     <= 1'b0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
                rdata  <= mem[rd_ptr];
            end
            if (push && !do_push) begin
                ovf <= 1'b1;
            end
            count_q <= count_q + CW'(do_push) - CW'(do_pop);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/ufc_dma_hs.sv
module ufc_dma_hs
    import ufc_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  dma_mode_e     mode,
    input  logic [CW-1:0] tx_count,
    input  logic          tx_full,
    input  logic [CW-1:0] tx_lvl,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] rx_lvl,
    input  logic          rx_timeout,
    output logic          txrdy_n,
    output logic          rxrdy_n
);

    logic tx_hold_q, tx_blk;
    logic rx_act_q, rx_act;

    // block mode transmit: hysteresis between threshold and full
    always_comb begin
        if (tx_full) begin
            tx_blk = 1'b1;
        end else if (tx_count <= tx_lvl) begin
            tx_blk = 1'b0;
        end else begin
            tx_blk = tx_hold_q;
        end
    end

    // block mode receive: armed by threshold or time-out, released on empty
    assign rx_act = (rx_count != '0) &&
                    ((rx_count >= rx_lvl) || rx_timeout || rx_act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_hold_q <= 1'b0;
            rx_act_q  <= 1'b0;
        end else begin
            tx_hold_q <= tx_blk;
            rx_act_q  <= rx_act;
        end
    end

    always_comb begin
        unique case (mode)
            DMA_BLOCK: begin
                txrdy_n = tx_blk;
                rxrdy_n = !rx_act;
            end
            default: begin
                txrdy_n = (tx_count != '0);
                rxrdy_n = (rx_count == '0);
            end
        endcase
    end

endmodule

// File: rtl/uart_fifo_dma_ctrl.sv
module uart_fifo_dma_ctrl
    import ufc_pkg::*;
#(
    parameter int unsigned DW    = UFC_DW,
    parameter int unsigned DEPTH = UFC_DEPTH
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           fcr_we,
    input  logic [7:0]                     fcr_wdata,
    output logic [7:0]                     fcr_rdata,
    input  logic                           tx_push,
    input  logic [DW-1:0]                  tx_wdata,
    input  logic                           tx_pop,
    output logic [DW-1:0]                  tx_rdata,
    output logic [$clog2(DEPTH+1)-1:0]     tx_count,
    output logic                           tx_ovf,
    input  logic                           rx_push,
    input  logic [DW-1:0]                  rx_wdata,
    input  logic                           rx_pop,
    output logic [DW-1:0]                  rx_rdata,
    output logic [$clog2(DEPTH+1)-1:0]     rx_count,
    output logic                           rx_ovf,
    input  logic                           rx_timeout,
    output logic                           txrdy_n,
    output logic                           rxrdy_n,
    output logic                           tx_trig_irq,
    output logic                           rx_trig_irq
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    ctl_reg_t      ctl_q;
    dma_mode_e     mode;
    logic          tx_flush;
    logic [CW-1:0] cap, tx_lvl, rx_lvl;

    ufc_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .we       (fcr_we),
        .wdata    (fcr_wdata),
        .ctl_q    (ctl_q),
        .tx_flush (tx_flush),
        .mode     (mode)
    );

    assign fcr_rdata = ctl_q;
    assign cap       = ctl_q.en ? CW'(DEPTH) : CW'(1);
    assign tx_lvl    = CW'(tx_threshold(ctl_q.tx_sel, DEPTH));
    assign rx_lvl    = CW'(rx_threshold(ctl_q.rx_sel, DEPTH));

    ufc_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_flush),
        .cap   (cap),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .count (tx_count),
        .ovf   (tx_ovf)
    );

    ufc_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (1'b0),
        .cap   (cap),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_count),
        .ovf   (rx_ovf)
    );

    ufc_dma_hs #(.CW(CW)) u_hs (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .tx_count   (tx_count),
        .tx_full    (tx_count >= cap),
        .tx_lvl     (tx_lvl),
        .rx_count   (rx_count),
        .rx_lvl     (rx_lvl),
        .rx_timeout (rx_timeout),
        .txrdy_n    (txrdy_n),
        .rxrdy_n    (rxrdy_n)
    );

    assign rx_trig_irq = ctl_q.en && (rx_count >= rx_lvl);
    assign tx_trig_irq = ctl_q.en && (tx_count < tx_lvl);

endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CW    = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          fcr_we,
    input logic [7:0]    fcr_wdata,
    input logic [7:0]    fcr_rdata,
    input logic [7:0]    rx_rdata,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          tx_ovf,
    input logic          rx_ovf,
    input logic          txrdy_n,
    input logic          rxrdy_n,
    input logic          tx_trig_irq,
    input logic          rx_trig_irq
);

    logic [CW-1:0] cap_c;
    logic          blk_c;
    assign cap_c = fcr_rdata[0] ? CW'(DEPTH) : CW'(1);
    assign blk_c = fcr_rdata[0] && fcr_rdata[3];

    assert_rdback_zero_R1: assert property (@(posedge clk) disable iff (rst)
        fcr_rdata[2:1] == 2'b00);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_push && !rx_pop && !fcr_we && rx_count >= cap_c)
            |=> (rx_ovf && $stable(rx_count)));

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && !rx_push && rx_count == '0)
            |=> ($stable(rx_rdata) && rx_count == '0));

    assert_tx_flush_R5: assert property (@(posedge clk) disable iff (rst)
        (fcr_we && fcr_wdata[2]) |=> (tx_count == '0 && !tx_ovf));

    assert_irq_off_R6: assert property (@(posedge clk) disable iff (rst)
        !fcr_rdata[0] |-> (!rx_trig_irq && !tx_trig_irq));

    assert_full_req_R11: assert property (@(posedge clk) disable iff (rst)
        (blk_c && tx_count == CW'(DEPTH)) |-> txrdy_n);

    assert_empty_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (blk_c && rx_count == '0) |-> rxrdy_n);

endmodule

bind uart_fifo_dma_ctrl ufc_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/uart_fifo_dma_ctrl_tb.sv
module uart_fifo_dma_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fcr_we = 1'b0;
    logic [7:0] fcr_wdata = '0;
    logic [7:0] fcr_rdata;
    logic       tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, tx_rdata;
    logic [5:0] tx_count, rx_count;
    logic       tx_ovf, rx_ovf;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_wdata = '0, rx_rdata;
    logic       rx_timeout = 1'b0;
    logic       txrdy_n, rxrdy_n, tx_trig_irq, rx_trig_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_fifo_dma_ctrl u_dut (
        .clk(clk), .rst(rst),
        .fcr_we(fcr_we), .fcr_wdata(fcr_wdata), .fcr_rdata(fcr_rdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_ovf(tx_ovf),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_ovf(rx_ovf),
        .rx_timeout(rx_timeout), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n),
        .tx_trig_irq(tx_trig_irq), .rx_trig_irq(rx_trig_irq)
    );

    // scoreboard model of both queues
    logic [7:0] txq[$], rxq[$];
    logic [7:0] fcr_m = '0;
    logic [7:0] tx_exp, rx_exp;
    bit         tx_pend = 0, rx_pend = 0;
    int         cap_m, n_m;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            txq.delete(); rxq.delete();
            fcr_m = '0; tx_pend = 0; rx_pend = 0;
        end else begin
            cap_m = fcr_m[0] ? 32 : 1;
            tx_pend = 0;
            if (fcr_we && fcr_wdata[2]) begin
                txq.delete();
            end else begin
                n_m = txq.size();
                if (tx_pop && n_m > 0) begin tx_exp = txq.pop_front(); tx_pend = 1; end
                if (tx_push && n_m < cap_m) txq.push_back(tx_wdata);
            end
            rx_pend = 0;
            n_m = rxq.size();
            if (rx_pop && n_m > 0) begin rx_exp = rxq.pop_front(); rx_pend = 1; end
            if (rx_push && n_m < cap_m) rxq.push_back(rx_wdata);
            if (fcr_we) fcr_m = fcr_wdata & 8'hF9;
        end
    end

    // monitor: compare popped bytes against queue order (R4)
    always @(negedge clk) begin
        if (!rst && rx_pend) chk("R4 rx pop order", int'(rx_rdata), int'(rx_exp));
        if (!rst && tx_pend) chk("R4 tx pop order", int'(tx_rdata), int'(tx_exp));
    end

    task automatic cyc(); @(negedge clk); endtask
    task automatic wr_fcr(input logic [7:0] v);
        fcr_we = 1'b1; fcr_wdata = v; cyc(); fcr_we = 1'b0;
    endtask
    task automatic push_rx(input logic [7:0] b);
        rx_push = 1'b1; rx_wdata = b; cyc(); rx_push = 1'b0;
    endtask
    task automatic pop_rx(); rx_pop = 1'b1; cyc(); rx_pop = 1'b0; endtask
    task automatic push_tx(input logic [7:0] b);
        tx_push = 1'b1; tx_wdata = b; cyc(); tx_push = 1'b0;
    endtask
    task automatic pop_tx(); tx_pop = 1'b1; cyc(); tx_pop = 1'b0; endtask
    task automatic do_reset();
        rst = 1'b1; cyc(); cyc(); rst = 1'b0; cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc();
        do_reset();
        // reset state
        chk("R1 reset value", fcr_rdata, 0);
        chk("R9 idle txrdy_n", txrdy_n, 0);
        chk("R10 idle rxrdy_n", rxrdy_n, 1);
        chk("R7 irq off when disabled", tx_trig_irq, 0);

        // holding-register mode
        push_rx(8'hA1); push_rx(8'hA2);
        chk("R2 single-byte capacity", rx_count, 1);
        chk("R3 overflow sticky", rx_ovf, 1);
        chk("R10 rxrdy_n with data", rxrdy_n, 0);
        push_tx(8'h11);
        chk("R9 txrdy_n loaded", txrdy_n, 1);
        pop_rx();
        chk("R10 rxrdy_n drained", rxrdy_n, 1);
        pop_rx();
        chk("R4 empty pop keeps data", rx_rdata, 8'hA1);
        chk("R4 empty pop count", rx_count, 0);
        wr_fcr(8'h08);
        push_rx(8'h33);
        chk("R8 mode bit ignored while disabled", rxrdy_n, 0);
        pop_rx(); pop_tx();

        // block mode, thresholds rx 8 / tx 16
        do_reset();
        wr_fcr(8'h0D);
        chk("R1 flush bit reads 0", fcr_rdata, 8'h09);
        for (int i = 0; i < 33; i++) begin
            push_tx(8'(8'h40 + i));
            if (i == 16) chk("R11 hold low rising", txrdy_n, 0);
            if (i == 31) chk("R11 high at full", txrdy_n, 1);
        end
        chk("R2 deep capacity", tx_count, 32);
        chk("R3 tx overflow", tx_ovf, 1);
        chk("R7 irq low when full", tx_trig_irq, 0);
        for (int i = 0; i < 15; i++) pop_tx();
        chk("R11 hold high falling", txrdy_n, 1);
        pop_tx();
        chk("R11 low at threshold", txrdy_n, 0);
        chk("R7 irq at threshold", tx_trig_irq, 0);
        pop_tx();
        chk("R7 irq below threshold", tx_trig_irq, 1);
        wr_fcr(8'h0D);
        chk("R5 flush count", tx_count, 0);
        chk("R5 flush ovf", tx_ovf, 0);
        chk("R5 flush keeps rdata", tx_rdata, 8'h50);

        for (int i = 0; i < 7; i++) push_rx(8'(8'h60 + i));
        chk("R12 below threshold", rxrdy_n, 1);
        chk("R6 irq below threshold", rx_trig_irq, 0);
        push_rx(8'h67);
        chk("R12 at threshold", rxrdy_n, 0);
        chk("R6 irq at threshold", rx_trig_irq, 1);
        for (int i = 0; i < 7; i++) pop_rx();
        chk("R12 stays low", rxrdy_n, 0);
        chk("R6 irq drops", rx_trig_irq, 0);
        pop_rx();
        chk("R12 released on empty", rxrdy_n, 1);

        push_rx(8'h70); push_rx(8'h71);
        chk("R12 partial fill idle", rxrdy_n, 1);
        rx_timeout = 1'b1; cyc(); rx_timeout = 1'b0;
        chk("R12 time-out arms", rxrdy_n, 0);
        cyc();
        chk("R12 time-out latched", rxrdy_n, 0);
        pop_rx(); pop_rx();
        rx_timeout = 1'b1; cyc(); rx_timeout = 1'b0;
        chk("R12 time-out on empty", rxrdy_n, 1);

        // other threshold codes
        wr_fcr(8'hC1);
        for (int i = 0; i < 27; i++) push_rx(8'(8'h80 + i));
        chk("R6 code 11 below", rx_trig_irq, 0);
        chk("R10 mode 0 rx", rxrdy_n, 0);
        push_rx(8'h9B);
        chk("R6 code 11 reached", rx_trig_irq, 1);
        for (int i = 0; i < 28; i++) pop_rx();
        wr_fcr(8'h11);
        chk("R7 code 01 empty", tx_trig_irq, 1);
        for (int i = 0; i < 8; i++) push_tx(8'(8'hC0 + i));
        chk("R7 code 01 reached", tx_trig_irq, 0);
        wr_fcr(8'h21);
        chk("R7 code 10", tx_trig_irq, 1);

        cyc();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule